// File: doc/BRIEF.md
# Triggered Shadow-Register PWM Generator

A multi-channel pulse-width modulator driven from a simple read/write register port. Every channel has a clock prescaler, a period count, a duty-high count, a polarity bit and an output-type bit. Software writes new values into a shadow register set. The values reach the running counters only when software raises that channel's trigger bit.

At the rising edge of the trigger bit, the channel's smooth bit selects how the new values are loaded. With smooth set, the new set is loaded at the end of the current period, so no pulse is cut short. With smooth clear, the new set is loaded after a fixed settling delay of `IMM_DLY` clocks. No enable bit exists. A channel whose trigger and smooth bits are both low drives a constant high. A duty count of zero holds the output at its inactive level.

Top module: `shadow_pwm`

## Requirements
- R1: The register port uses byte addresses. The control word is at 0x00: trigger of channel c at bit c, polarity at bit 8+c, output type at bit 16+c, smooth at bit 24+c. The prescale word is at 0x04, with a 3-bit field per channel at bit 4*c; the fourth bit of each field reads as zero. The period count of channel c is at 0x08+8*c and its duty count at 0x0C+8*c; both are 24 bits wide, and the upper bits read as zero. Reads are combinational from `addr_i`.
- R2: After reset all registers read zero and every output is high.
- R3: Shadow writes do not change a running output until the trigger bit of that channel rises from 0 to 1. Writes made while the trigger stays high do not load. A falling edge of the trigger does not load.
- R4: If smooth is 0 when the trigger rises, the new set becomes active `IMM_DLY` clocks after the clock edge that detects the rise. The output reflects the new set one clock later.
- R5: If smooth is 1 when the trigger rises, the new set becomes active only at the end of the running period.
- R6: While the trigger and smooth bits of a channel are both 0, its output is constant high. Otherwise the active waveform runs.
- R7: One period lasts (prescale+1)*PC clocks. The duty phase at the start of each period lasts (prescale+1)*DC clocks.
- R8: DC = 0 keeps the output at its inactive level for the whole period. DC >= PC keeps it at its active level for the whole period.
- R9: A polarity bit of 1 drives the output high during the duty phase. A polarity bit of 0 inverts the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Write strobe |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` |
| pwm_o | output | NCH | Registered channel outputs |

## Verification
The hardest case to reach is the smooth load: a load at the end of the period must be told apart from a delayed load. The stimulus runs a channel with a long period, waits for the falling edge that ends the duty phase, and then triggers a smooth load. The remaining low phase is longer than the fixed delay, so a delayed load would show a toggle inside that window and a correct design shows none. The delayed load itself is timed to the exact clock by switching from a constant-active setting to a zero-duty setting.

// File: rtl/spwm_pkg.sv
package spwm_pkg;
  localparam int DATA_W      = 32;
  localparam int PRE_W       = 3;
  localparam int OFS_CTRL    = 'h00;
  localparam int OFS_PRE     = 'h04;
  localparam int OFS_CH_BASE = 'h08;
  localparam int CH_STRIDE   = 8;
  localparam int DUTY_OFS    = 4;
  localparam int PRE_FIELD   = 4;
  localparam int CTRL_POL    = 8;
  localparam int CTRL_TYPE   = 16;
  localparam int CTRL_SMOOTH = 24;

  function automatic int pc_addr(int c);
    return OFS_CH_BASE + CH_STRIDE * c;
  endfunction

  function automatic int dc_addr(int c);
    return pc_addr(c) + DUTY_OFS;
  endfunction
endpackage

// File: rtl/spwm_regs.sv
module spwm_regs
  import spwm_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int CNT_W  = 24,
  parameter int ADDR_W = 6
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             we_i,
  input  logic [ADDR_W-1:0]                addr_i,
  input  logic [DATA_W-1:0]                wdata_i,
  output logic [DATA_W-1:0]                rdata_o,
  output logic [NCH-1:0]                   trig_o,
  output logic [NCH-1:0]                   smooth_o,
  output logic [NCH-1:0]                   pol_o,
  output logic [NCH-1:0][PRE_W-1:0]        pre_o,
  output logic [NCH-1:0][CNT_W-1:0]        pc_o,
  output logic [NCH-1:0][CNT_W-1:0]        dc_o
);
  logic [NCH-1:0] typ_q;
  logic           unused_wdata;
  int             a_int;

  assign a_int        = int'(addr_i);
  assign unused_wdata = ^wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trig_o   <= '0;
      smooth_o <= '0;
      pol_o    <= '0;
      typ_q    <= '0;
      pre_o    <= '0;
      pc_o     <= '0;
      dc_o     <= '0;
    end else if (we_i) begin
      for (int c = 0; c < NCH; c++) begin
        if (a_int == OFS_CTRL) begin
          trig_o[c]   <= wdata_i[c];
          pol_o[c]    <= wdata_i[CTRL_POL+c];
          typ_q[c]    <= wdata_i[CTRL_TYPE+c];
          smooth_o[c] <= wdata_i[CTRL_SMOOTH+c];
        end
        if (a_int == OFS_PRE) pre_o[c] <= wdata_i[PRE_FIELD*c +: PRE_W];
        if (a_int == pc_addr(c)) pc_o[c] <= wdata_i[CNT_W-1:0];
        if (a_int == dc_addr(c)) dc_o[c] <= wdata_i[CNT_W-1:0];
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int c = 0; c < NCH; c++) begin
      if (a_int == OFS_CTRL) begin
        rdata_o[c]             = trig_o[c];
        rdata_o[CTRL_POL+c]    = pol_o[c];
        rdata_o[CTRL_TYPE+c]   = typ_q[c];
        rdata_o[CTRL_SMOOTH+c] = smooth_o[c];
      end
      if (a_int == OFS_PRE) rdata_o[PRE_FIELD*c +: PRE_W] = pre_o[c];
      if (a_int == pc_addr(c)) rdata_o[CNT_W-1:0] = pc_o[c];
      if (a_int == dc_addr(c)) rdata_o[CNT_W-1:0] = dc_o[c];
    end
  end
endmodule

// File: rtl/spwm_trig.sv
module spwm_trig #(
  parameter int IMM_DLY = 100
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  input  logic smooth_i,
  input  logic bnd_i,
  output logic load_o,
  output logic pend_s_o
);
  localparam int DLY_W = $clog2(IMM_DLY + 1);

  logic             trig_q, rise, pend_f_q;
  logic [DLY_W-1:0] dly_q;

  assign rise   = trig_i & ~trig_q;
  assign load_o = ~rise & ((pend_f_q & (dly_q == '0)) | (pend_s_o & bnd_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trig_q   <= 1'b0;
      pend_f_q <= 1'b0;
      pend_s_o <= 1'b0;
      dly_q    <= '0;
    end else begin
      trig_q <= trig_i;
      if (rise) begin
        pend_s_o <= smooth_i;
        pend_f_q <= ~smooth_i;
        dly_q    <= DLY_W'(IMM_DLY - 1);
      end else if (pend_f_q) begin
        if (dly_q == '0) pend_f_q <= 1'b0;
        else             dly_q    <= dly_q - 1'b1;
      end else if (pend_s_o && bnd_i) begin
        pend_s_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/spwm_core.sv
module spwm_core #(
  parameter int CNT_W = 24,
  parameter int PRE_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             idle_i,
  input  logic [PRE_W-1:0] sh_pre_i,
  input  logic [CNT_W-1:0] sh_pc_i,
  input  logic [CNT_W-1:0] sh_dc_i,
  input  logic             sh_pol_i,
  output logic             pwm_o,
  output logic             bnd_o,
  output logic [CNT_W-1:0] act_pc_o,
  output logic [CNT_W-1:0] act_dc_o,
  output logic             act_pol_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic [PRE_W-1:0] act_pre_q, pre_cnt_q;
  logic             tick, last, duty, wave;

  assign tick  = (pre_cnt_q == act_pre_q);
  assign last  = (act_pc_o < CNT_W'(2)) || (cnt_o >= act_pc_o - CNT_W'(1));
  assign bnd_o = tick & last;
  assign duty  = (cnt_o < act_dc_o);
  assign wave  = act_pol_o ? duty : ~duty;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_pre_q <= '0;
      act_pc_o  <= '0;
      act_dc_o  <= '0;
      act_pol_o <= 1'b0;
      pre_cnt_q <= '0;
      cnt_o     <= '0;
      pwm_o     <= 1'b1;
    end else begin
      pwm_o <= idle_i ? 1'b1 : wave;
      if (load_i) begin
        act_pre_q <= sh_pre_i;
        act_pc_o  <= sh_pc_i;
        act_dc_o  <= sh_dc_i;
        act_pol_o <= sh_pol_i;
        pre_cnt_q <= '0;
        cnt_o     <= '0;
      end else if (tick) begin
        pre_cnt_q <= '0;
        cnt_o     <= last ? '0 : cnt_o + 1'b1;
      end else begin
        pre_cnt_q <= pre_cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/shadow_pwm.sv
module shadow_pwm
  import spwm_pkg::*;
#(
  parameter int NCH     = 4,
  parameter int CNT_W   = 24,
  parameter int IMM_DLY = 100,
  parameter int ADDR_W  = $clog2(OFS_CH_BASE + CH_STRIDE * NCH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic [NCH-1:0]    pwm_o
);
  logic [NCH-1:0]              trig, smooth, pol, load, pend_s, bnd, act_pol;
  logic [NCH-1:0][PRE_W-1:0]   sh_pre;
  logic [NCH-1:0][CNT_W-1:0]   sh_pc, sh_dc, act_pc, act_dc, cnt;

  spwm_regs #(.NCH(NCH), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
    .clk_i, .rst_ni, .we_i, .addr_i, .wdata_i, .rdata_o,
    .trig_o(trig), .smooth_o(smooth), .pol_o(pol),
    .pre_o(sh_pre), .pc_o(sh_pc), .dc_o(sh_dc)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    spwm_trig #(.IMM_DLY(IMM_DLY)) u_trig (
      .clk_i, .rst_ni,
      .trig_i(trig[c]), .smooth_i(smooth[c]), .bnd_i(bnd[c]),
      .load_o(load[c]), .pend_s_o(pend_s[c])
    );
    spwm_core #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_core (
      .clk_i, .rst_ni,
      .load_i(load[c]), .idle_i(~trig[c] & ~smooth[c]),
      .sh_pre_i(sh_pre[c]), .sh_pc_i(sh_pc[c]), .sh_dc_i(sh_dc[c]), .sh_pol_i(pol[c]),
      .pwm_o(pwm_o[c]), .bnd_o(bnd[c]),
      .act_pc_o(act_pc[c]), .act_dc_o(act_dc[c]), .act_pol_o(act_pol[c]), .cnt_o(cnt[c])
    );
  end
endmodule

// File: rtl/shadow_pwm_chk.sv
module shadow_pwm_chk #(
  parameter int NCH   = 4,
  parameter int CNT_W = 24
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic [NCH-1:0]            pwm_o,
  input logic [NCH-1:0]            trig,
  input logic [NCH-1:0]            smooth,
  input logic [NCH-1:0]            load,
  input logic [NCH-1:0]            pend_s,
  input logic [NCH-1:0]            bnd,
  input logic [NCH-1:0]            act_pol,
  input logic [NCH-1:0][CNT_W-1:0] act_pc,
  input logic [NCH-1:0][CNT_W-1:0] act_dc,
  input logic [NCH-1:0][CNT_W-1:0] cnt
);
  for (genvar c = 0; c < NCH; c++) begin : g_a
    AST_ACT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !load[c] |=> $stable(act_pc[c]) && $stable(act_dc[c]) && $stable(act_pol[c])); // R3
    AST_SMOOTH_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pend_s[c] && !bnd[c]) |-> !load[c]); // R5
    AST_IDLE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!trig[c] && !smooth[c]) |=> pwm_o[c]); // R6
    AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (act_pc[c] >= CNT_W'(2)) |-> (cnt[c] < act_pc[c])); // R7
    AST_ZERO_DUTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (act_dc[c] == '0 && (trig[c] || smooth[c])) |=> pwm_o[c] == !$past(act_pol[c])); // R8
  end
endmodule

bind shadow_pwm shadow_pwm_chk #(.NCH(NCH), .CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .pwm_o(pwm_o), .trig(trig), .smooth(smooth),
  .load(load), .pend_s(pend_s), .bnd(bnd), .act_pol(act_pol),
  .act_pc(act_pc), .act_dc(act_dc), .cnt(cnt)
);

// File: tb/shadow_pwm_tb.sv
module shadow_pwm_tb;
  localparam int IMM = 100;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        we_i = 1'b0;
  logic [5:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [3:0]  pwm_o;

  int total = 0, bad = 0;
  logic [31:0] ctrl_sh = '0, pre_sh = '0;

  shadow_pwm #(.NCH(4), .CNT_W(24), .IMM_DLY(IMM)) u_dut (
    .clk_i, .rst_ni, .we_i, .addr_i, .wdata_i, .rdata_o, .pwm_o
  );

  always #2 clk_i = ~clk_i;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk_i);
    we_i = 1'b1; addr_i = 6'(a); wdata_i = d;
    @(negedge clk_i);
    we_i = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk_i);
    addr_i = 6'(a);
    #1 d = rdata_o;
  endtask

  task automatic count_high(input int ch, input int n, output int h);
    h = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      if (pwm_o[ch]) h++;
    end
  endtask

  task automatic cfg(input int ch, input int pre, input int pc, input int dc, input bit pol);
    pre_sh[4*ch +: 3] = 3'(pre);
    wr('h04, pre_sh);
    wr('h08 + 8*ch, 32'(pc));
    wr('h0C + 8*ch, 32'(dc));
    ctrl_sh[8+ch] = pol;
    wr('h00, ctrl_sh);
  endtask

  task automatic prepare(input int ch);
    ctrl_sh[ch] = 1'b0; ctrl_sh[24+ch] = 1'b1;
    wr('h00, ctrl_sh);
  endtask

  task automatic fire(input int ch, input bit smooth);
    ctrl_sh[ch] = 1'b1; ctrl_sh[24+ch] = smooth;
    wr('h00, ctrl_sh);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    check(pwm_o == 4'hF, "R2 outputs high", pwm_o, 4'hF);
    rd('h00, d); check(d == 0, "R2 ctrl zero", d, 0);
    rd('h2C - 8, d); check(d == 0, "R2 duty ch3 zero", d, 0);
  endtask

  task automatic t_regs;
    logic [31:0] d;
    wr('h10, 32'hFFAB_CDEF); rd('h10, d);
    check(d == 32'h00AB_CDEF, "R1 period ch1 24-bit", d, 32'h00AB_CDEF);
    wr('h24, 32'h1234_5678); rd('h24, d);
    check(d == 32'h0034_5678, "R1 duty ch3", d, 32'h0034_5678);
    wr('h04, 32'hFFFF_FFFF); rd('h04, d);
    check(d == 32'h0000_7777, "R1 prescale fields", d, 32'h7777);
    ctrl_sh = 32'h000F_0000;
    wr('h00, ctrl_sh); rd('h00, d);
    check(d == 32'h000F_0000, "R1 type bits", d, 32'h000F_0000);
    check(pwm_o == 4'hF, "R6 type bits keep idle", pwm_o, 4'hF);
    wr('h04, 0); pre_sh = '0;
  endtask

  task automatic t_fast_basic;
    int h;
    cfg(0, 0, 10, 3, 1'b1);
    count_high(0, 40, h);
    check(h == 40, "R3 idle until trigger", h, 40);
    prepare(0); fire(0, 1'b0);
    repeat (IMM + 20) @(negedge clk_i);
    count_high(0, 100, h);
    check(h == 30, "R7 duty 3 of 10", h, 30);
    wr('h0C, 7);
    repeat (150) @(negedge clk_i);
    count_high(0, 100, h);
    check(h == 30, "R3 write with trigger held high", h, 30);
    prepare(0);
    repeat (IMM + 20) @(negedge clk_i);
    count_high(0, 100, h);
    check(h == 30, "R3 falling edge no load", h, 30);
    fire(0, 1'b0);
    repeat (IMM + 20) @(negedge clk_i);
    count_high(0, 100, h);
    check(h == 70, "R4 fast load applies", h, 70);
  endtask

  task automatic t_fast_timing;
    int h;
    cfg(1, 0, 400, 400, 1'b1);
    prepare(1); fire(1, 1'b0);
    repeat (IMM + 20) @(negedge clk_i);
    count_high(1, 200, h);
    check(h == 200, "R8 duty >= period full active", h, 200);
    wr('h10, 10); wr('h14, 0);
    prepare(1); fire(1, 1'b0);
    repeat (IMM + 1) @(negedge clk_i);
    check(pwm_o[1] == 1'b1, "R4 not loaded before delay", pwm_o[1], 1);
    @(negedge clk_i);
    check(pwm_o[1] == 1'b0, "R4 loaded after delay", pwm_o[1], 0);
    count_high(1, 100, h);
    check(h == 0, "R8 zero duty inactive", h, 0);
  endtask

  task automatic t_smooth;
    int h;
    cfg(2, 0, 200, 50, 1'b1);
    prepare(2); fire(2, 1'b0);
    repeat (IMM + 250) @(negedge clk_i);
    wr('h18, 10); wr('h1C, 5);
    do @(negedge clk_i); while (pwm_o[2] != 1'b1);
    do @(negedge clk_i); while (pwm_o[2] != 1'b0);
    prepare(2); fire(2, 1'b1);
    count_high(2, IMM + 20, h);
    check(h == 0, "R5 held until period end", h, 0);
    repeat (100) @(negedge clk_i);
    count_high(2, 100, h);
    check(h == 50, "R5 new set after boundary", h, 50);
    ctrl_sh[2] = 1'b0; ctrl_sh[26] = 1'b0;
    wr('h00, ctrl_sh);
    count_high(2, 60, h);
    check(h == 60, "R6 trigger and smooth low forces high", h, 60);
  endtask

  task automatic t_pol_pre;
    int h;
    cfg(3, 0, 10, 3, 1'b0);
    prepare(3); fire(3, 1'b0);
    repeat (IMM + 20) @(negedge clk_i);
    count_high(3, 100, h);
    check(h == 70, "R9 inverted polarity", h, 70);
    cfg(3, 2, 4, 1, 1'b1);
    prepare(3); fire(3, 1'b0);
    repeat (IMM + 20) @(negedge clk_i);
    count_high(3, 60, h);
    check(h == 15, "R7 prescale 2 period 12", h, 15);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    t_reset();
    t_regs();
    t_fast_basic();
    t_fast_timing();
    t_smooth();
    t_pol_pre();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    total++; bad++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule